// File: doc/BRIEF.md
# Virtual Channel Credit Flow Controller

This block runs credit-based flow control for a point-to-point packet link that carries several independent virtual channels. On the transmit side it holds a count per channel of the receive buffers still free at the link partner. It offers a packet slot only to channels that have both a pending packet and at least one credit, and it rotates among eligible channels round-robin. A credit is spent on the edge where a packet is accepted into the transmit queue.

On the receive side, user logic signals each freed local buffer. The events gather in per-channel pending counters. While any of them is nonzero, the block asks for a NOP control packet. That NOP carries a small credit-return field for each channel. Credits from NOPs sent by the partner come in through a one-cycle decode stage before they are added to the transmit counts.

Channel indices are 0 posted, 1 non-posted and 2 response. Each credit field of a NOP is RET_W bits wide, and field v sits at bits [v*RET_W +: RET_W].

Top module: `vc_credit_ctrl`

## Requirements
- R1: While rst_n is low, each channel's credit count loads from its CNT_W-bit field of init_credit (field v at bits [v*CNT_W +: CNT_W]). A value above MAX_CREDIT loads as MAX_CREDIT. After reset there are no pending returns, no NOP request and no error.
- R2: When sched_valid and sched_ready are both high, the credit count of sched_vc is one lower after that edge.
- R3: sched_valid is high only if the channel named by sched_vc has pkt_req set and a nonzero credit count.
- R4: A channel with zero credits does not block the others: sched_valid is high whenever any channel has a request and credits.
- R5: The grant goes to the first eligible channel after the last accepted channel, in ascending cyclic order of index. After reset the search starts at channel 0. sched_vc is the binary channel index.
- R6: Each buf_free bit adds one to that channel's pending count. nop_req is high exactly while any pending count is nonzero.
- R7: Field v of nop_credits equals min(pending[v], 2^RET_W-1). On a cycle with nop_req and nop_ack both high, only that reported amount is taken from pending[v]. The excess carries over, and same-cycle buf_free events are still added.
- R8: Credits from rx_nop_valid/rx_nop_credits are applied to the counts one cycle after they are presented, because they pass a decode stage first. They are visible after the second rising edge.
- R9: An increment and a decrement of the same channel in the same cycle give the net result.
- R10: Credit counts saturate at MAX_CREDIT and pending counts saturate at 2^PEND_W-1. Any attempt to go beyond either limit sets overflow_err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads initial credits |
| init_credit | input | NUM_VC*CNT_W | Initial credit count per channel |
| pkt_req | input | NUM_VC | Channel has a packet waiting to be scheduled |
| sched_ready | input | 1 | Transmit queue accepts a packet this cycle |
| sched_valid | output | 1 | A channel is granted a packet slot |
| sched_vc | output | VC_W | Index of the granted channel |
| credit_avail | output | NUM_VC*CNT_W | Current credit count per channel |
| buf_free | input | NUM_VC | Local receive buffer freed, one bit per channel |
| nop_req | output | 1 | Request to send a credit-return NOP |
| nop_credits | output | NUM_VC*RET_W | Credit-return fields for the NOP |
| nop_ack | input | 1 | NOP accepted this cycle |
| rx_nop_valid | input | 1 | An incoming NOP is present |
| rx_nop_credits | input | NUM_VC*RET_W | Credit-return fields of the incoming NOP |
| overflow_err | output | 1 | Sticky saturation error flag |

## Verification
The bench builds the block with three channels, CNT_W=3, MAX_CREDIT=6 and PEND_W=3, so both counter ceilings are only a few events away. With these limits, saturation, exhaustion and carry-over of pending credits all happen many times in a few thousand cycles. A sweep of initial values from 0 to 7 covers the clamp at reset. Pseudo-random traffic phases then alternate between draining credits with no returns and flooding returns. Each phase is checked cycle by cycle against an arithmetic model of counts, pointer, pending totals and the decode delay.

// File: rtl/vc_credit_ctrl.sv
module vc_credit_ctrl #(
  parameter int NUM_VC     = 3,
  parameter int CNT_W      = 4,
  parameter int MAX_CREDIT = 12,
  parameter int RET_W      = 2,
  parameter int PEND_W     = 4,
  localparam int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int RET_MAX   = (1 << RET_W) - 1,
  localparam int PEND_MAX  = (1 << PEND_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_VC*CNT_W-1:0]   init_credit,
  input  logic [NUM_VC-1:0]         pkt_req,
  input  logic                      sched_ready,
  output logic                      sched_valid,
  output logic [VC_W-1:0]           sched_vc,
  output logic [NUM_VC*CNT_W-1:0]   credit_avail,
  input  logic [NUM_VC-1:0]         buf_free,
  output logic                      nop_req,
  output logic [NUM_VC*RET_W-1:0]   nop_credits,
  input  logic                      nop_ack,
  input  logic                      rx_nop_valid,
  input  logic [NUM_VC*RET_W-1:0]   rx_nop_credits,
  output logic                      overflow_err
);

  logic [CNT_W-1:0]        cnt  [NUM_VC];
  logic [PEND_W-1:0]       pend [NUM_VC];
  logic [RET_W-1:0]        rep  [NUM_VC];
  logic [RET_W-1:0]        inc  [NUM_VC];
  logic [NUM_VC-1:0]       elig, cnt_ovf, pend_ovf, pend_nz;
  logic                    rxq_v;
  logic [NUM_VC*RET_W-1:0] rxq_cr;
  logic [VC_W-1:0]         last, gnt;
  logic                    gnt_ok, acc_sched, acc_nop, err;

  // rotating search starting after the last accepted channel (R5)
  always_comb begin
    gnt_ok = 1'b0;
    gnt    = last;
    for (int i = 1; i <= NUM_VC; i++) begin
      int k;
      k = (int'(last) + i) % NUM_VC;
      if (!gnt_ok && elig[k]) begin
        gnt_ok = 1'b1;
        gnt    = VC_W'(k);
      end
    end
  end

  assign sched_valid  = gnt_ok;
  assign sched_vc     = gnt;
  assign acc_sched    = gnt_ok && sched_ready;
  assign nop_req      = |pend_nz;
  assign acc_nop      = nop_req && nop_ack;
  assign overflow_err = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last   <= VC_W'(NUM_VC - 1);
      rxq_v  <= 1'b0;
      rxq_cr <= '0;
      err    <= 1'b0;
    end else begin
      if (acc_sched) last <= gnt;
      rxq_v  <= rx_nop_valid;
      rxq_cr <= rx_nop_credits;
      err    <= err || (|cnt_ovf) || (|pend_ovf);
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CNT_W-1:0]  init_f, init_v;
    logic [CNT_W+1:0]  csum;
    logic [PEND_W:0]   psum;
    logic              dec;

    assign init_f     = init_credit[v*CNT_W +: CNT_W];
    assign init_v     = (int'(init_f) > MAX_CREDIT) ? CNT_W'(MAX_CREDIT) : init_f;
    assign elig[v]    = pkt_req[v] && (cnt[v] != '0);
    assign dec        = acc_sched && (gnt == VC_W'(v));
    assign inc[v]     = rxq_v ? rxq_cr[v*RET_W +: RET_W] : '0;
    assign csum       = {2'b00, cnt[v]} + (CNT_W+2)'(inc[v]) - (CNT_W+2)'(dec);
    assign cnt_ovf[v] = csum > (CNT_W+2)'(MAX_CREDIT);

    assign rep[v]      = (int'(pend[v]) > RET_MAX) ? RET_W'(RET_MAX) : pend[v][RET_W-1:0];
    assign psum        = {1'b0, pend[v]} - (acc_nop ? (PEND_W+1)'(rep[v]) : '0)
                       + (PEND_W+1)'(buf_free[v]);
    assign pend_ovf[v] = psum > (PEND_W+1)'(PEND_MAX);
    assign pend_nz[v]  = pend[v] != '0;

    assign credit_avail[v*CNT_W +: CNT_W] = cnt[v];
    assign nop_credits[v*RET_W +: RET_W]  = rep[v];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[v]  <= init_v;
        pend[v] <= '0;
      end else begin
        cnt[v]  <= cnt_ovf[v]  ? CNT_W'(MAX_CREDIT) : csum[CNT_W-1:0];
        pend[v] <= pend_ovf[v] ? PEND_W'(PEND_MAX)  : psum[PEND_W-1:0];
      end
    end

    p_dec_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sched && gnt == VC_W'(v) && inc[v] == '0) |=> cnt[v] == $past(cnt[v]) - 1'b1);

    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_nop |=> pend[v] >= $past(pend[v]));

    p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rxq_v && !acc_sched) |=> cnt[v] == $past(cnt[v]));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt[v]) <= MAX_CREDIT);
  end

  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> (pkt_req[sched_vc] && credit_avail[sched_vc*CNT_W +: CNT_W] != '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

endmodule

// File: tb/sim_vc_credit_ctrl.sv
module sim_vc_credit_ctrl;
  localparam int NV = 3, CW = 3, MX = 6, RW = 2, PW = 3, PMX = 7, RMX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NV*CW-1:0] init_credit = '0;
  logic [NV-1:0] pkt_req = '0, buf_free = '0;
  logic sched_ready = 1'b0, nop_ack = 1'b0, rx_nop_valid = 1'b0;
  logic [NV*RW-1:0] rx_nop_credits = '0;
  logic sched_valid, nop_req, overflow_err;
  logic [1:0] sched_vc;
  logic [NV*CW-1:0] credit_avail;
  logic [NV*RW-1:0] nop_credits;

  int checks = 0, errors = 0;
  int mcnt[NV], mpend[NV], mptr, merr, rqv, rqcr[NV];
  logic [31:0] lf = 32'h1234_5678;

  always #10 clk = ~clk;

  vc_credit_ctrl #(.NUM_VC(NV), .CNT_W(CW), .MAX_CREDIT(MX), .RET_W(RW), .PEND_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .init_credit(init_credit), .pkt_req(pkt_req),
    .sched_ready(sched_ready), .sched_valid(sched_valid), .sched_vc(sched_vc),
    .credit_avail(credit_avail), .buf_free(buf_free), .nop_req(nop_req),
    .nop_credits(nop_credits), .nop_ack(nop_ack), .rx_nop_valid(rx_nop_valid),
    .rx_nop_credits(rx_nop_credits), .overflow_err(overflow_err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic do_reset(input int i0, input int i1, input int i2);
    @(negedge clk);
    rst_n = 1'b0;
    init_credit = {CW'(i2), CW'(i1), CW'(i0)};
    pkt_req = '0; buf_free = '0; sched_ready = 0; nop_ack = 0; rx_nop_valid = 0; rx_nop_credits = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mcnt[0] = (i0 > MX) ? MX : i0;
    mcnt[1] = (i1 > MX) ? MX : i1;
    mcnt[2] = (i2 > MX) ? MX : i2;
    for (int v = 0; v < NV; v++) begin mpend[v] = 0; rqcr[v] = 0; end
    mptr = NV - 1; merr = 0; rqv = 0;
    #1;
    for (int v = 0; v < NV; v++)
      check(int'(credit_avail[v*CW +: CW]) == mcnt[v], "R1 reset credit", int'(credit_avail[v*CW +: CW]), mcnt[v]);
    check(!nop_req, "R1 reset nop_req", int'(nop_req), 0);
    check(!overflow_err, "R1 reset err", int'(overflow_err), 0);
    check(!sched_valid, "R1 reset no grant", int'(sched_valid), 0);
  endtask

  // one cycle: drive at negedge, compare outputs with the model, advance the model
  task automatic step(input int phase);
    int eg, any, g, s, p, rep;
    bit acc;
    @(negedge clk);
    lf = nxt(lf);
    pkt_req     = lf[2:0];
    sched_ready = (lf[4:3] != 2'b00);
    buf_free    = (phase == 2) ? 3'b111 : lf[7:5];
    nop_ack     = (phase == 2) ? (lf[9:8] == 2'b00) : lf[8];
    rx_nop_valid   = (phase == 0) ? 1'b0 : (phase == 1) ? lf[10] : (lf[11:10] == 2'b00);
    rx_nop_credits = lf[17:12];
    #1;
    g = -1; any = 0;
    for (int i = 1; i <= NV; i++) begin
      eg = (mptr + i) % NV;
      if (pkt_req[eg] && mcnt[eg] != 0) begin
        any = 1;
        if (g < 0) g = eg;
      end
    end
    check(sched_valid == (any != 0), "R4 grant present when eligible", int'(sched_valid), any);
    if (sched_valid && g >= 0) begin
      check(int'(sched_vc) == g, "R5 round-robin choice", int'(sched_vc), g);
      check(pkt_req[sched_vc] && mcnt[sched_vc] != 0, "R3 granted channel eligible", int'(sched_vc), g);
    end
    p = 0;
    for (int v = 0; v < NV; v++) if (mpend[v] != 0) p = 1;
    check(nop_req == (p != 0), "R6 nop_req", int'(nop_req), p);
    for (int v = 0; v < NV; v++) begin
      rep = (mpend[v] > RMX) ? RMX : mpend[v];
      check(int'(nop_credits[v*RW +: RW]) == rep, "R7 nop credit field", int'(nop_credits[v*RW +: RW]), rep);
      check(int'(credit_avail[v*CW +: CW]) == mcnt[v], "R2 R8 R9 credit count", int'(credit_avail[v*CW +: CW]), mcnt[v]);
    end
    check(int'(overflow_err) == merr, "R10 overflow flag", int'(overflow_err), merr);
    acc = (any != 0) && sched_ready;
    for (int v = 0; v < NV; v++) begin
      s = mcnt[v] + (rqv ? rqcr[v] : 0) - ((acc && g == v) ? 1 : 0);
      if (s > MX) begin mcnt[v] = MX; merr = 1; end else mcnt[v] = s;
      rep = (mpend[v] > RMX) ? RMX : mpend[v];
      s = mpend[v] - ((p != 0 && nop_ack) ? rep : 0) + int'(buf_free[v]);
      if (s > PMX) begin mpend[v] = PMX; merr = 1; end else mpend[v] = s;
    end
    if (acc) mptr = g;
    rqv = rx_nop_valid;
    for (int v = 0; v < NV; v++) rqcr[v] = int'(rx_nop_credits[v*RW +: RW]);
  endtask

  initial begin
    // R1: clamp sweep over every encodable initial value
    for (int i = 0; i < 8; i++) do_reset(i, 7 - i, (i + 3) % 8);
    // R2 R3 R4 R5: drain with no returns, channels exhaust one by one
    do_reset(1, 4, 6);
    for (int c = 0; c < 400; c++) step(0);
    // R6 R7 R8 R9: mixed returns and drains
    do_reset(2, 5, 1);
    for (int c = 0; c < 2000; c++) step(1);
    // R10: flood of returns and frees pushes both ceilings
    do_reset(6, 6, 6);
    for (int c = 0; c < 1500; c++) step(2);
    do_reset(3, 0, 5);
    for (int c = 0; c < 1500; c++) step(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule